// File: doc/BRIEF.md
# Control-Transfer Target and Link Unit

This block sits beside the decode stage of a 32-bit load/store core that executes one instruction after every taken control transfer (a delay slot). For each issued instruction it recognises the unconditional region jumps, the register jumps and the conditional branches. It works out the destination address and decides whether the transfer is taken. Where the instruction links, it also produces the register write that saves the return address.

A taken destination is not sent to the fetch unit at once. It is parked in a pending register. When the instruction in the delay slot retires (`slot_done_i`), the pending register raises a one-cycle redirect carrying the parked address and then empties. A "likely" branch that falls through raises `annul_o` so that the delay-slot instruction is squashed. The return address saved by every linking form is the transfer's PC plus 8, which is the first instruction after the delay slot.

Top module: `xfer_target_unit`

## Requirements
- R1: Instruction fields are taken from fixed bit positions: primary opcode [31:26], rt [20:16], rd [15:11], function [5:0], jump index [25:0] and immediate [15:0]. Opcode 2 is a region jump. Its target is the top 4 bits of the PC joined with index<<2, and it writes no link.
- R2: Opcode 3 is a region jump with link. It has the same target as R1 and writes PC+8 into register 31.
- R3: Opcode 0 with function 0x08 is always taken, targets the rs operand value and writes no link.
- R4: Opcode 0 with function 0x09 targets the rs operand value. It writes PC+8 into register rd when rd is nonzero, and writes nothing when rd is 0.
- R5: Conditional branches target PC + 4 + (sign-extended immediate << 2). Opcodes 4 and 0x14 are taken when rs equals rt. Opcodes 5 and 0x15 are taken when rs differs from rt.
- R6: Opcodes 6 and 0x16 are taken when rs is signed less than or equal to zero. Opcodes 7 and 0x17 are taken when rs is signed greater than zero.
- R7: Under opcode 1, rt codes 0x00, 0x02, 0x10 and 0x12 are taken when rs is negative. Codes 0x01, 0x03, 0x11 and 0x13 are taken when rs is non-negative. Codes 0x10 to 0x13 write PC+8 into register 31 whether or not the branch is taken.
- R8: `annul_o` is 1 only for a likely branch that is issued and not taken. The likely forms are opcodes 0x14 to 0x17 and opcode-1 rt codes with bit 1 set. Normal branches and taken branches never annul.
- R9: A taken transfer loads its target into the pending register at the next clock. A not-taken or non-transfer instruction leaves the pending register as it was.
- R10: While a target is pending, `slot_done_i` raises `redirect_o` in the same cycle with the pending address on `redirect_addr_o`, and the pending register empties at the next clock.
- R11: If `slot_done_i` arrives in the same cycle as a new taken transfer, the redirect reports the old target and the pending register holds the new one afterwards.
- R12: The asynchronous active-low reset empties the pending register and clears the pending address to 0.
- R13: With `issue_i` low, or for any instruction outside R1 to R7, `taken_o`, `annul_o` and `link_we_o` are all 0 and the pending register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction on `instr_i` is being issued this cycle |
| pc_i | input | XLEN | Address of the issued instruction |
| instr_i | input | 32 | Issued instruction word |
| rs_val_i | input | XLEN | Value of register rs |
| rt_val_i | input | XLEN | Value of register rt |
| slot_done_i | input | 1 | Delay-slot instruction retires this cycle |
| taken_o | output | 1 | Issued instruction transfers control |
| annul_o | output | 1 | Squash the delay-slot instruction |
| link_we_o | output | 1 | Write the return address this cycle |
| link_idx_o | output | 5 | Register index of the link write |
| link_data_o | output | XLEN | Return address (PC+8) |
| pend_valid_o | output | 1 | A target is pending |
| pend_addr_o | output | XLEN | Pending target address |
| redirect_o | output | 1 | Fetch must go to `redirect_addr_o` |
| redirect_addr_o | output | XLEN | Redirect destination |

## Verification
The assertions assume the core issues at most one instruction per cycle. They also assume that `slot_done_i` is meaningful only while a target is pending, and that the operand values belong to the instruction issued in the same cycle. The directed tasks drive a single issue per cycle and hold `issue_i` low between instructions. They pulse `slot_done_i` alone, except in the one scenario that deliberately overlaps it with a new taken transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int OP_W      = 6;
  localparam int REG_IDX_W = 5;
  localparam int FUNCT_W   = 6;
  localparam int JIDX_W    = 26;
  localparam int IMM_W     = 16;
  localparam int REGION_W  = 4;

  localparam logic [REG_IDX_W-1:0] LINK_REG = 5'd31;

  typedef enum logic [3:0] {
    XK_NONE   = 4'd0,
    XK_REGION = 4'd1,
    XK_REG    = 4'd2,
    XK_EQ     = 4'd3,
    XK_NE     = 4'd4,
    XK_LEZ    = 4'd5,
    XK_GTZ    = 4'd6,
    XK_LTZ    = 4'd7,
    XK_GEZ    = 4'd8
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e             kind;
    logic                   likely;
    logic                   link_en;
    logic [REG_IDX_W-1:0]   link_idx;
  } xfer_dec_t;

  function automatic logic kind_is_cond(xfer_kind_e k);
    return (k == XK_EQ) || (k == XK_NE) || (k == XK_LEZ) ||
           (k == XK_GTZ) || (k == XK_LTZ) || (k == XK_GEZ);
  endfunction
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [OP_W-1:0]      op_i,
  input  logic [REG_IDX_W-1:0] rt_f_i,
  input  logic [REG_IDX_W-1:0] rd_f_i,
  input  logic [FUNCT_W-1:0]   funct_i,
  output xfer_dec_t            dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (op_i)
      6'h00: begin
        if (funct_i == 6'h08) begin
          dec_o.kind = XK_REG;
        end else if (funct_i == 6'h09) begin
          dec_o.kind     = XK_REG;
          dec_o.link_en  = (rd_f_i != '0);
          dec_o.link_idx = rd_f_i;
        end
      end
      6'h01: begin
        // rt codes 0x00-0x03 and 0x10-0x13 only
        if (rt_f_i[3:2] == 2'b00) begin
          dec_o.kind     = rt_f_i[0] ? XK_GEZ : XK_LTZ;
          dec_o.likely   = rt_f_i[1];
          dec_o.link_en  = rt_f_i[4];
          dec_o.link_idx = LINK_REG;
        end
      end
      6'h02: dec_o.kind = XK_REGION;
      6'h03: begin
        dec_o.kind     = XK_REGION;
        dec_o.link_en  = 1'b1;
        dec_o.link_idx = LINK_REG;
      end
      default: begin
        // opcodes 0x04-0x07 and their likely twins 0x14-0x17
        if (!op_i[5] && !op_i[3] && op_i[2]) begin
          dec_o.likely = op_i[4];
          unique case (op_i[1:0])
            2'b00: dec_o.kind = XK_EQ;
            2'b01: dec_o.kind = XK_NE;
            2'b10: dec_o.kind = XK_LEZ;
            default: dec_o.kind = XK_GTZ;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/xfer_cond.sv
module xfer_cond
  import xfer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  xfer_kind_e        kind_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic              cond_o
);
  logic neg, zero, equal;

  assign neg   = rs_i[XLEN-1];
  assign zero  = (rs_i == '0);
  assign equal = (rs_i == rt_i);

  always_comb begin
    unique case (kind_i)
      XK_EQ:   cond_o = equal;
      XK_NE:   cond_o = !equal;
      XK_LEZ:  cond_o = neg || zero;
      XK_GTZ:  cond_o = !neg && !zero;
      XK_LTZ:  cond_o = neg;
      XK_GEZ:  cond_o = !neg;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_target.sv
module xfer_target
  import xfer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  xfer_kind_e        kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   rs_i,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   link_o
);
  localparam int REGION_LO = JIDX_W + 2;
  localparam int PAD_W     = XLEN - REGION_W - REGION_LO;
  localparam int SEXT_W    = XLEN - IMM_W - 2;

  logic [XLEN-1:0] region_tgt, branch_tgt, imm_off, seq_pc;

  generate
    if (PAD_W > 0) begin : g_region_pad
      assign region_tgt = {pc_i[XLEN-1 -: REGION_W], {PAD_W{1'b0}}, jidx_i, 2'b00};
    end else begin : g_region_flat
      assign region_tgt = {pc_i[XLEN-1 -: REGION_W], jidx_i, 2'b00};
    end
  endgenerate

  assign imm_off    = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign seq_pc     = pc_i + XLEN'(4);
  assign branch_tgt = seq_pc + imm_off;
  // return point skips the delay slot
  assign link_o     = pc_i + XLEN'(8);

  always_comb begin
    unique case (kind_i)
      XK_REGION: target_o = region_tgt;
      XK_REG:    target_o = rs_i;
      default:   target_o = branch_tgt;
    endcase
  end
endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit
  import xfer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [31:0]          instr_i,
  input  logic [XLEN-1:0]      rs_val_i,
  input  logic [XLEN-1:0]      rt_val_i,
  input  logic                 slot_done_i,
  output logic                 taken_o,
  output logic                 annul_o,
  output logic                 link_we_o,
  output logic [REG_IDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]      link_data_o,
  output logic                 pend_valid_o,
  output logic [XLEN-1:0]      pend_addr_o,
  output logic                 redirect_o,
  output logic [XLEN-1:0]      redirect_addr_o
);
  xfer_dec_t       dec;
  logic            cond, is_cond, is_jump;
  logic [XLEN-1:0] target;
  logic            pend_q;
  logic [XLEN-1:0] pend_addr_q;

  xfer_decode u_dec (
    .op_i    (instr_i[31:26]),
    .rt_f_i  (instr_i[20:16]),
    .rd_f_i  (instr_i[15:11]),
    .funct_i (instr_i[5:0]),
    .dec_o   (dec)
  );

  xfer_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (dec.kind),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .cond_o (cond)
  );

  xfer_target #(.XLEN(XLEN)) u_tgt (
    .kind_i   (dec.kind),
    .pc_i     (pc_i),
    .jidx_i   (instr_i[25:0]),
    .imm_i    (instr_i[15:0]),
    .rs_i     (rs_val_i),
    .target_o (target),
    .link_o   (link_data_o)
  );

  assign is_cond    = kind_is_cond(dec.kind);
  assign is_jump    = (dec.kind == XK_REGION) || (dec.kind == XK_REG);
  assign taken_o    = issue_i && (is_jump || (is_cond && cond));
  assign annul_o    = issue_i && is_cond && dec.likely && !cond;
  assign link_we_o  = issue_i && dec.link_en;
  assign link_idx_o = dec.link_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else if (taken_o) begin
      pend_q      <= 1'b1;
      pend_addr_q <= target;
    end else if (slot_done_i) begin
      pend_q      <= 1'b0;
    end
  end

  assign pend_valid_o    = pend_q;
  assign pend_addr_o     = pend_addr_q;
  assign redirect_o      = slot_done_i && pend_q;
  assign redirect_addr_o = pend_addr_q;

  assert_link_never_r0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_idx_o != '0));

  assert_annul_not_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> (!taken_o && dec.likely));

  assert_taken_loads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> (pend_valid_o && pend_addr_o == $past(target)));

  assert_slot_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_done_i && !taken_o) |=> !pend_valid_o);

  assert_idle_holds_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i && !slot_done_i) |=> ($stable(pend_valid_o) && $stable(pend_addr_o)));

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> (!taken_o && !annul_o && !link_we_o));
endmodule

// File: tb/tb_xfer_target_unit.sv
module tb_xfer_target_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic        slot_done_i = 1'b0;
  logic        taken_o, annul_o, link_we_o, pend_valid_o, redirect_o;
  logic [4:0]  link_idx_o;
  logic [31:0] link_data_o, pend_addr_o, redirect_addr_o;

  int checks = 0;
  int errors = 0;
  logic g_taken, g_annul, g_lwe, g_redir;
  logic [4:0]  g_lidx;
  logic [31:0] g_ldata, g_raddr;

  always #10 clk = ~clk;

  xfer_target_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i), .pc_i(pc_i),
    .instr_i(instr_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .slot_done_i(slot_done_i), .taken_o(taken_o), .annul_o(annul_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_data_o(link_data_o),
    .pend_valid_o(pend_valid_o), .pend_addr_o(pend_addr_o),
    .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
    return {op, 5'd0, rt, imm};
  endfunction
  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] mk_r(input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, 5'd3, 5'd0, rd, 5'd0, fn};
  endfunction

  task automatic do_issue(input logic [31:0] pc, input logic [31:0] ins,
                          input logic [31:0] rsv, input logic [31:0] rtv, input logic sd);
    @(negedge clk);
    issue_i = 1'b1; pc_i = pc; instr_i = ins; rs_val_i = rsv; rt_val_i = rtv; slot_done_i = sd;
    #2;
    g_taken = taken_o; g_annul = annul_o; g_lwe = link_we_o; g_lidx = link_idx_o;
    g_ldata = link_data_o; g_redir = redirect_o; g_raddr = redirect_addr_o;
    @(negedge clk);
    issue_i = 1'b0; slot_done_i = 1'b0;
  endtask

  task automatic do_slot();
    @(negedge clk);
    slot_done_i = 1'b1;
    #2;
    g_redir = redirect_o; g_raddr = redirect_addr_o;
    @(negedge clk);
    slot_done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "pend_valid", {31'd0, pend_valid_o}, 32'd0);
    chk("R12", "pend_addr", pend_addr_o, 32'd0);
    chk("R12", "redirect", {31'd0, redirect_o}, 32'd0);
  endtask

  task automatic t_region();
    logic [31:0] pc = 32'h8000_1000;
    do_issue(pc, mk_j(6'h02, 26'h0123456), 32'd0, 32'd0, 1'b0);
    chk("R1", "taken", {31'd0, g_taken}, 32'd1);
    chk("R1", "link_we", {31'd0, g_lwe}, 32'd0);
    chk("R1", "pend_valid", {31'd0, pend_valid_o}, 32'd1);
    chk("R1", "target", pend_addr_o, 32'h8048_D158);
    do_slot();
    chk("R10", "redirect", {31'd0, g_redir}, 32'd1);
    chk("R10", "redirect_addr", g_raddr, 32'h8048_D158);
    chk("R10", "pend_empty", {31'd0, pend_valid_o}, 32'd0);
    pc = 32'h3FFF_FFF0;
    do_issue(pc, mk_j(6'h03, 26'h3FFFFFF), 32'd0, 32'd0, 1'b0);
    chk("R2", "link_we", {31'd0, g_lwe}, 32'd1);
    chk("R2", "link_idx", {27'd0, g_lidx}, 32'd31);
    chk("R2", "link_data", g_ldata, 32'h3FFF_FFF8);
    chk("R2", "target", pend_addr_o, 32'h3FFF_FFFC);
    do_slot();
  endtask

  task automatic t_regjump();
    do_issue(32'h0000_0100, mk_r(5'd0, 6'h08), 32'h1234_5678, 32'd0, 1'b0);
    chk("R3", "taken", {31'd0, g_taken}, 32'd1);
    chk("R3", "link_we", {31'd0, g_lwe}, 32'd0);
    chk("R3", "target", pend_addr_o, 32'h1234_5678);
    do_slot();
    do_issue(32'h0000_0200, mk_r(5'd5, 6'h09), 32'hCAFE_0000, 32'd0, 1'b0);
    chk("R4", "link_we", {31'd0, g_lwe}, 32'd1);
    chk("R4", "link_idx", {27'd0, g_lidx}, 32'd5);
    chk("R4", "link_data", g_ldata, 32'h0000_0208);
    chk("R4", "target", pend_addr_o, 32'hCAFE_0000);
    do_slot();
    do_issue(32'h0000_0300, mk_r(5'd0, 6'h09), 32'hBEEF_0000, 32'd0, 1'b0);
    chk("R4", "rd0_no_link", {31'd0, g_lwe}, 32'd0);
    chk("R4", "rd0_taken", {31'd0, g_taken}, 32'd1);
    do_slot();
  endtask

  task automatic t_eq();
    do_issue(32'h0000_1000, mk_i(6'h04, 5'd0, 16'hFFFE), 32'd7, 32'd7, 1'b0);
    chk("R5", "beq_taken", {31'd0, g_taken}, 32'd1);
    chk("R5", "beq_target", pend_addr_o, 32'h0000_0FFC);
    do_issue(32'h0000_1000, mk_i(6'h05, 5'd0, 16'h0040), 32'd7, 32'd7, 1'b0);
    chk("R5", "bne_eq_not_taken", {31'd0, g_taken}, 32'd0);
    chk("R8", "normal_no_annul", {31'd0, g_annul}, 32'd0);
    chk("R9", "not_taken_keeps_addr", pend_addr_o, 32'h0000_0FFC);
    chk("R9", "not_taken_keeps_valid", {31'd0, pend_valid_o}, 32'd1);
    do_slot();
    do_issue(32'h0000_1000, mk_i(6'h05, 5'd0, 16'h0040), 32'd7, 32'd8, 1'b0);
    chk("R5", "bne_taken_target", pend_addr_o, 32'h0000_1104);
    do_slot();
  endtask

  task automatic t_zero();
    do_issue(32'h0000_2000, mk_i(6'h06, 5'd0, 16'h0010), 32'd0, 32'd0, 1'b0);
    chk("R6", "blez_zero", {31'd0, g_taken}, 32'd1);
    chk("R6", "blez_target", pend_addr_o, 32'h0000_2044);
    do_slot();
    do_issue(32'h0000_2000, mk_i(6'h06, 5'd0, 16'h0010), 32'hFFFF_FFFF, 32'd0, 1'b0);
    chk("R6", "blez_neg", {31'd0, g_taken}, 32'd1);
    do_slot();
    do_issue(32'h0000_2000, mk_i(6'h06, 5'd0, 16'h0010), 32'd1, 32'd0, 1'b0);
    chk("R6", "blez_pos", {31'd0, g_taken}, 32'd0);
    do_issue(32'h0000_2000, mk_i(6'h07, 5'd0, 16'h0010), 32'd1, 32'd0, 1'b0);
    chk("R6", "bgtz_pos", {31'd0, g_taken}, 32'd1);
    do_slot();
    do_issue(32'h0000_2000, mk_i(6'h07, 5'd0, 16'h0010), 32'h8000_0000, 32'd0, 1'b0);
    chk("R6", "bgtz_minneg", {31'd0, g_taken}, 32'd0);
  endtask

  task automatic t_regimm();
    do_issue(32'h0000_4000, mk_i(6'h01, 5'h10, 16'h0004), 32'd5, 32'd0, 1'b0);
    chk("R7", "ltzal_not_taken", {31'd0, g_taken}, 32'd0);
    chk("R7", "ltzal_link_we", {31'd0, g_lwe}, 32'd1);
    chk("R7", "ltzal_link_idx", {27'd0, g_lidx}, 32'd31);
    chk("R7", "ltzal_link_data", g_ldata, 32'h0000_4008);
    do_issue(32'h0000_4000, mk_i(6'h01, 5'h11, 16'h0004), 32'd5, 32'd0, 1'b0);
    chk("R7", "gezal_taken", {31'd0, g_taken}, 32'd1);
    chk("R7", "gezal_link", {31'd0, g_lwe}, 32'd1);
    chk("R7", "gezal_target", pend_addr_o, 32'h0000_4014);
    do_slot();
    do_issue(32'h0000_4000, mk_i(6'h01, 5'h01, 16'h0004), 32'hFFFF_FFFF, 32'd0, 1'b0);
    chk("R7", "gez_neg_not_taken", {31'd0, g_taken}, 32'd0);
    chk("R7", "gez_no_link", {31'd0, g_lwe}, 32'd0);
    do_issue(32'h0000_4000, mk_i(6'h01, 5'h00, 16'h0004), 32'hFFFF_FFFF, 32'd0, 1'b0);
    chk("R7", "ltz_neg_taken", {31'd0, g_taken}, 32'd1);
    do_slot();
  endtask

  task automatic t_likely();
    do_issue(32'h0000_5000, mk_i(6'h14, 5'd0, 16'h0002), 32'd1, 32'd2, 1'b0);
    chk("R8", "beql_annul", {31'd0, g_annul}, 32'd1);
    chk("R8", "beql_not_taken", {31'd0, g_taken}, 32'd0);
    do_issue(32'h0000_5000, mk_i(6'h14, 5'd0, 16'h0002), 32'd2, 32'd2, 1'b0);
    chk("R8", "beql_taken_no_annul", {31'd0, g_annul}, 32'd0);
    chk("R5", "beql_target", pend_addr_o, 32'h0000_500C);
    do_slot();
    do_issue(32'h0000_5000, mk_i(6'h01, 5'h12, 16'h0002), 32'd5, 32'd0, 1'b0);
    chk("R8", "ltzall_annul", {31'd0, g_annul}, 32'd1);
    chk("R7", "ltzall_link", {31'd0, g_lwe}, 32'd1);
    do_issue(32'h0000_5000, mk_i(6'h17, 5'd0, 16'h0002), 32'd0, 32'd0, 1'b0);
    chk("R8", "bgtzl_annul", {31'd0, g_annul}, 32'd1);
  endtask

  task automatic t_inert();
    do_issue(32'h0000_6000, mk_j(6'h03, 26'h0000040), 32'd0, 32'd0, 1'b0);
    do_issue(32'h0000_6100, mk_i(6'h09, 5'd4, 16'h1234), 32'd0, 32'd0, 1'b0);
    chk("R13", "addi_taken", {31'd0, g_taken}, 32'd0);
    chk("R13", "addi_link", {31'd0, g_lwe}, 32'd0);
    do_issue(32'h0000_6100, mk_i(6'h01, 5'h0C, 16'h1234), 32'd0, 32'd0, 1'b0);
    chk("R13", "regimm_other", {30'd0, g_taken, g_lwe}, 32'd0);
    do_issue(32'h0000_6100, mk_r(5'd7, 6'h20), 32'd0, 32'd0, 1'b0);
    chk("R13", "funct_other", {29'd0, g_taken, g_lwe, g_annul}, 32'd0);
    chk("R13", "pend_kept", pend_addr_o, 32'h0000_0100);
    @(negedge clk);
    instr_i = mk_j(6'h03, 26'h1); issue_i = 1'b0;
    #2;
    chk("R13", "no_issue_quiet", {29'd0, taken_o, link_we_o, annul_o}, 32'd0);
    @(negedge clk);
    chk("R13", "no_issue_keeps", pend_addr_o, 32'h0000_0100);
  endtask

  task automatic t_overlap();
    do_issue(32'h0000_7000, mk_j(6'h02, 26'h0000200), 32'd0, 32'd0, 1'b1);
    chk("R11", "redirect_old", {31'd0, g_redir}, 32'd1);
    chk("R11", "redirect_old_addr", g_raddr, 32'h0000_0100);
    chk("R11", "pend_new_valid", {31'd0, pend_valid_o}, 32'd1);
    chk("R11", "pend_new_addr", pend_addr_o, 32'h0000_0800);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    chk("R12", "async_clear_valid", {31'd0, pend_valid_o}, 32'd0);
    chk("R12", "async_clear_addr", pend_addr_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_region();
    t_regjump();
    t_eq();
    t_zero();
    t_regimm();
    t_likely();
    t_inert();
    t_overlap();
    t_mid_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule